// File: doc/BRIEF.md
# Circular Trace Capture Controller

This block turns a wide stream of monitor samples into 128-bit lines for a circular trace RAM. Each kept sample gives one slice of 64, 32, 16 or 8 bits, taken from a shifted view of the sample. Slices are packed into a line starting at the least significant end. The line is written once it is full. A divider can thin the stream so that only one enabled cycle out of every X is kept.

While enabled, the controller records without stopping and wraps its write pointer around a region. The region starts at a line address built from an 8-bit start field with ten low zero bits. It ends at an address built from an 8-bit end field with ten low one bits. When the trigger arrives, the controller latches two values: the line address it was about to fill, and how many slices the partial line already held. It then writes a programmed number of further lines and halts, so the RAM holds both history and aftermath. A first-fill flag stays high until the pointer has wrapped once, which tells software that part of the region still holds stale data.

Configuration inputs may change only while the block is disabled. The block must stay disabled for at least one cycle before it is enabled, so that the write pointer loads the start address.

Top module: `trace_capture_ctrl`

## Requirements
- R1: width_mode selects the slice width: 0 gives 64 bits, 1 gives 32, 2 gives 16 and 3 gives 8. Slice k of a line occupies bits [k*w +: w]. A line is written after 2, 4, 8 or 16 kept samples, respectively.
- R2: With rate_div = X > 1, exactly one enabled cycle out of every X is kept, and the first enabled cycle is kept. Values 0 and 1 keep every cycle.
- R3: shift_sel shifts the 96-bit sample right before slicing: 0 gives no shift, 1 gives 16 bits, 2 gives 32 bits and 3 gives 64 bits. Vacated bits are zero.
- R4: The first line after enabling is written to {start_msb, 10'h000}. Each later line goes to the next address. The line after {end_msb, 10'h3FF} goes back to {start_msb, 10'h000}.
- R5: ram_we is a one-cycle pulse. It is high in the cycle after the clock edge that samples the slice completing a line, and it is never high in two consecutive cycles.
- R6: cap_state reads 0 while seeking the trigger, 1 after it, and 2 when halted. A trigger sampled while enabled and in state 0 moves the block to state 1 on the same edge.
- R7: At the trigger edge, evt_addr takes the address of the line being filled. At the same edge, evt_phase takes the number of slices already in that line (0 means empty).
- R8: After the trigger, exactly post_lines further lines are written and then the state becomes 2. A value of 0 halts at once. No line is written in state 2.
- R9: first_fill is 1 out of reset. It falls when the line at the end address is written, and it returns to 1 whenever cap_en is low.
- R10: With cap_en low, the state goes to 0, no line is written, and the divider and packing position clear.
- R11: A trigger seen in state 1 or 2 changes neither evt_addr nor evt_phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable |
| trig_in | input | 1 | Final trigger |
| width_mode | input | 2 | Slice width select |
| shift_sel | input | 2 | Right shift applied to the sample |
| rate_div | input | 5 | Keep one cycle out of this many |
| start_msb | input | 8 | Upper bits of the region start line |
| end_msb | input | 8 | Upper bits of the region end line |
| post_lines | input | 18 | Lines to write after the trigger |
| sample_in | input | 96 | Monitor sample |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 18 | RAM line address |
| ram_wdata | output | 128 | RAM line data |
| cap_state | output | 2 | Capture state |
| evt_addr | output | 18 | Line address at the trigger |
| evt_phase | output | 4 | Slices held at the trigger |
| first_fill | output | 1 | Region not yet wrapped |

## Verification
Every output is a register. Each output therefore reflects the inputs sampled at one rising edge and is valid right after that edge. This covers the write strobe, address and data for a line completed by a sample, the state change on a trigger, and the event latches. The bench drives inputs just after the falling edge. A behavioural model built from queues of slices updates on the same rising edge as the design. All outputs are compared with the model at the next falling edge, so the expected values are due exactly one edge after the stimulus. Scenario checks on halting, disable and repeated triggers are sampled one full edge after the input change, and later again to confirm that nothing more is written.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_POST = 2'd1,
        ST_HALT = 2'd2
    } cap_state_e;

endpackage

// File: rtl/trace_decim.sv
module trace_decim #(
    parameter int RATE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    output logic              keep
);
    logic [RATE_W-1:0] div_d, div_q;
    logic [RATE_W:0]   div_inc;

    assign keep    = en && (div_q == '0);
    assign div_inc = {1'b0, div_q} + {{RATE_W{1'b0}}, 1'b1};

    always_comb begin
        div_d = div_q;
        if (!en) begin
            div_d = '0;
        end else if (div_inc >= {1'b0, rate}) begin
            div_d = '0;
        end else begin
            div_d = div_inc[RATE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // a kept cycle is followed by a dropped one whenever the divider exceeds 1
    assert_keep_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (keep && rate > 1) |=> !keep);

endmodule

// File: rtl/trace_slicer.sv
module trace_slicer #(
    parameter int SAMPLE_W = 96,
    parameter int WORD_W   = 64
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [1:0]          shift_sel,
    input  logic [1:0]          width_mode,
    output logic [WORD_W-1:0]   slice
);
    logic [SAMPLE_W-1:0] shifted;
    int                  keep_bits;

    always_comb begin
        case (shift_sel)
            2'd0:    shifted = sample;
            2'd1:    shifted = sample >> 16;
            2'd2:    shifted = sample >> 32;
            default: shifted = sample >> 64;
        endcase
    end

    always_comb begin
        keep_bits = WORD_W >> width_mode;
        for (int i = 0; i < WORD_W; i++) begin
            slice[i] = shifted[i] && (i < keep_bits);
        end
    end

endmodule

// File: rtl/trace_packer.sv
module trace_packer #(
    parameter int LINE_W = 128,
    parameter int WORD_W = 64,
    localparam int LANES = LINE_W / 8,
    localparam int PH_W  = $clog2(LANES)
) (
    input  logic [LINE_W-1:0] line_q,
    input  logic [PH_W-1:0]   slot,
    input  logic [1:0]        width_mode,
    input  logic [WORD_W-1:0] slice,
    output logic [LINE_W-1:0] line_d,
    output logic              full
);
    int lanes_per;
    int slots;

    always_comb begin
        lanes_per = (WORD_W / 8) >> width_mode;
        slots     = LANES / lanes_per;
    end

    always_comb begin
        line_d = line_q;
        for (int j = 0; j < LANES; j++) begin
            if ((j / lanes_per) == int'(slot)) begin
                line_d[j*8 +: 8] = slice[(j % lanes_per)*8 +: 8];
            end
        end
    end

    assign full = int'(slot) >= (slots - 1);

endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl
    import trace_cap_pkg::*;
#(
    parameter int SAMPLE_W = 96,
    parameter int WORD_W   = 64,
    parameter int LINE_W   = 128,
    parameter int ADDR_W   = 18,
    parameter int MSB_W    = 8,
    parameter int RATE_W   = 5,
    localparam int LOW_W   = ADDR_W - MSB_W,
    localparam int PH_W    = $clog2(LINE_W / 8)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_en,
    input  logic                trig_in,
    input  logic [1:0]          width_mode,
    input  logic [1:0]          shift_sel,
    input  logic [RATE_W-1:0]   rate_div,
    input  logic [MSB_W-1:0]    start_msb,
    input  logic [MSB_W-1:0]    end_msb,
    input  logic [ADDR_W-1:0]   post_lines,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [LINE_W-1:0]   ram_wdata,
    output logic [1:0]          cap_state,
    output logic [ADDR_W-1:0]   evt_addr,
    output logic [PH_W-1:0]     evt_phase,
    output logic                first_fill
);
    localparam logic [ADDR_W-1:0] ONE_A = 1;

    typedef struct packed {
        cap_state_e        state;
        logic [PH_W-1:0]   slot;
        logic [LINE_W-1:0] line;
        logic [ADDR_W-1:0] waddr;
        logic [ADDR_W-1:0] post_left;
        logic [ADDR_W-1:0] evt_ptr;
        logic [PH_W-1:0]   evt_phase;
        logic              first_fill;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [LINE_W-1:0] wr_data;
    } regs_t;

    regs_t d, q;

    logic              keep;
    logic [WORD_W-1:0] slice;
    logic [LINE_W-1:0] packed_line;
    logic              line_full;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] last_addr;

    assign base_addr = {start_msb, {LOW_W{1'b0}}};
    assign last_addr = {end_msb, {LOW_W{1'b1}}};

    trace_decim #(.RATE_W(RATE_W)) u_decim (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cap_en),
        .rate  (rate_div),
        .keep  (keep)
    );

    trace_slicer #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_slicer (
        .sample     (sample_in),
        .shift_sel  (shift_sel),
        .width_mode (width_mode),
        .slice      (slice)
    );

    trace_packer #(.LINE_W(LINE_W), .WORD_W(WORD_W)) u_packer (
        .line_q     (q.line),
        .slot       (q.slot),
        .width_mode (width_mode),
        .slice      (slice),
        .line_d     (packed_line),
        .full       (line_full)
    );

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (!cap_en) begin
            d.state      = ST_SEEK;
            d.slot       = '0;
            d.line       = '0;
            d.waddr      = base_addr;
            d.post_left  = '0;
            d.first_fill = 1'b1;
        end else begin
            if (q.state == ST_SEEK && trig_in) begin
                d.evt_ptr   = q.waddr;
                d.evt_phase = q.slot;
                if (post_lines == '0) begin
                    d.state = ST_HALT;
                end else begin
                    d.state     = ST_POST;
                    d.post_left = post_lines;
                end
            end
            if (q.state != ST_HALT && keep) begin
                d.line = packed_line;
                if (line_full) begin
                    d.slot    = '0;
                    d.wr_en   = 1'b1;
                    d.wr_addr = q.waddr;
                    d.wr_data = packed_line;
                    if (q.waddr == last_addr) begin
                        d.waddr      = base_addr;
                        d.first_fill = 1'b0;
                    end else begin
                        d.waddr = q.waddr + ONE_A;
                    end
                    if (q.state == ST_POST) begin
                        d.post_left = q.post_left - ONE_A;
                        if (q.post_left == ONE_A) begin
                            d.state = ST_HALT;
                        end
                    end
                end else begin
                    d.slot = q.slot + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.first_fill <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ram_we     = q.wr_en;
    assign ram_addr   = q.wr_addr;
    assign ram_wdata  = q.wr_data;
    assign cap_state  = q.state;
    assign evt_addr   = q.evt_ptr;
    assign evt_phase  = q.evt_phase;
    assign first_fill = q.first_fill;

    assert_write_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |=> !q.wr_en);

    assert_no_write_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HALT && $past(q.state == ST_HALT)) |-> !q.wr_en);

    assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> (q.state == ST_SEEK && !q.wr_en));

    assert_fill_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> q.first_fill);

    assert_event_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_SEEK && $past(q.state != ST_SEEK))
            |-> ($stable(q.evt_ptr) && $stable(q.evt_phase)));

endmodule

// File: tb/tb_trace_capture_ctrl.sv
module tb_trace_capture_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_en = 1'b0;
    logic         trig_in = 1'b0;
    logic [1:0]   width_mode = 2'd0;
    logic [1:0]   shift_sel = 2'd0;
    logic [4:0]   rate_div = 5'd0;
    logic [7:0]   start_msb = 8'd0;
    logic [7:0]   end_msb = 8'd0;
    logic [17:0]  post_lines = 18'd0;
    logic [95:0]  sample_in = '0;
    logic         ram_we;
    logic [17:0]  ram_addr;
    logic [127:0] ram_wdata;
    logic [1:0]   cap_state;
    logic [17:0]  evt_addr;
    logic [3:0]   evt_phase;
    logic         first_fill;

    always #5 clk = ~clk;

    trace_capture_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .trig_in(trig_in),
        .width_mode(width_mode), .shift_sel(shift_sel), .rate_div(rate_div),
        .start_msb(start_msb), .end_msb(end_msb), .post_lines(post_lines),
        .sample_in(sample_in), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .cap_state(cap_state), .evt_addr(evt_addr),
        .evt_phase(evt_phase), .first_fill(first_fill)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int wcount = 0;
    bit cmp_on = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int           m_state = 0;
    int           m_div = 0;
    int           m_post = 0;
    int           m_old;
    bit           m_keep;
    logic [63:0]  m_q[$];
    logic [17:0]  m_addr = '0;
    logic [17:0]  m_evt_ptr = '0;
    logic [3:0]   m_phase = '0;
    bit           m_ff = 1'b1;
    bit           e_we = 1'b0;
    logic [17:0]  e_addr = '0;
    logic [127:0] e_data = '0;

    function automatic logic [63:0] m_slice(input logic [95:0] s, input int mode, input int sh);
        logic [95:0] v;
        int w;
        v = s >> ((sh == 3) ? 64 : sh * 16);
        w = 64 >> mode;
        if (w == 64) return v[63:0];
        return v[63:0] & ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [127:0] m_build(input int mode);
        logic [127:0] l;
        int w;
        l = '0;
        w = 64 >> mode;
        foreach (m_q[i]) l = l | ({64'd0, m_q[i]} << (i * w));
        return l;
    endfunction

    always @(posedge clk) begin
        e_we = 1'b0;
        if (!rst_n) begin
            m_state = 0; m_div = 0; m_q.delete(); m_addr = '0;
            m_evt_ptr = '0; m_phase = '0; m_ff = 1'b1;
        end else if (!cap_en) begin
            m_state = 0; m_div = 0; m_q.delete();
            m_addr = {start_msb, 10'h000}; m_ff = 1'b1;
        end else begin
            m_old  = m_state;
            m_keep = (m_div == 0);
            m_div  = (m_div + 1 >= int'(rate_div)) ? 0 : m_div + 1;
            if (m_old == 0 && trig_in) begin
                m_evt_ptr = m_addr;
                m_phase   = 4'(m_q.size());
                if (post_lines == 0) m_state = 2;
                else begin m_state = 1; m_post = int'(post_lines); end
            end
            if (m_old != 2 && m_keep) begin
                m_q.push_back(m_slice(sample_in, int'(width_mode), int'(shift_sel)));
                if (m_q.size() == (2 << width_mode)) begin
                    e_we   = 1'b1;
                    e_addr = m_addr;
                    e_data = m_build(int'(width_mode));
                    m_q.delete();
                    if (m_addr == {end_msb, 10'h3FF}) begin
                        m_addr = {start_msb, 10'h000};
                        m_ff   = 1'b0;
                    end else begin
                        m_addr = m_addr + 18'd1;
                    end
                    if (m_old == 1) begin
                        m_post--;
                        if (m_post == 0) m_state = 2;
                    end
                end
            end
        end
    end

    always @(negedge clk) sample_in <= {$urandom(), $urandom(), $urandom()};

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n && cmp_on) begin
            chk(ram_we === e_we, "R2 R5 ram_we", {127'd0, ram_we}, {127'd0, e_we});
            if (e_we) begin
                chk(ram_addr === e_addr, "R4 ram_addr", {110'd0, ram_addr}, {110'd0, e_addr});
                chk(ram_wdata === e_data, "R1 R3 ram_wdata", ram_wdata, e_data);
            end
            chk(cap_state === 2'(m_state), "R6 cap_state", {126'd0, cap_state}, 128'(m_state));
            chk(evt_addr === m_evt_ptr, "R7 evt_addr", {110'd0, evt_addr}, {110'd0, m_evt_ptr});
            chk(evt_phase === m_phase, "R7 evt_phase", {124'd0, evt_phase}, {124'd0, m_phase});
            chk(first_fill === m_ff, "R9 first_fill", {127'd0, first_fill}, {127'd0, m_ff});
            if (ram_we) wcount++;
        end
        if (cyc > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic setup(input int mode, input int sh, input int rate,
                         input int st, input int en_m, input int post);
        cap_en     = 1'b0;
        width_mode = 2'(mode);
        shift_sel  = 2'(sh);
        rate_div   = 5'(rate);
        start_msb  = 8'(st);
        end_msb    = 8'(en_m);
        post_lines = 18'(post);
        step(2);
        cap_en = 1'b1;
    endtask

    int base;
    logic [17:0] saved_ptr;

    initial begin
        step(3);
        chk(cap_state === 2'd0, "R6 reset state", {126'd0, cap_state}, 128'd0);
        chk(first_fill === 1'b1, "R9 reset first_fill", {127'd0, first_fill}, 128'd1);
        chk(ram_we === 1'b0, "R5 reset ram_we", {127'd0, ram_we}, 128'd0);
        rst_n  = 1'b1;
        cmp_on = 1'b1;
        step(2);

        // 64-bit slices, full wrap of region 0, five post lines
        setup(0, 0, 0, 0, 0, 5);
        step(2100);
        chk(first_fill === 1'b0, "R9 wrapped", {127'd0, first_fill}, 128'd0);
        trig_in = 1'b1;
        step(1);
        trig_in = 1'b0;
        base = wcount;
        step(40);
        chk(cap_state === 2'd2, "R8 halted", {126'd0, cap_state}, 128'd2);
        chk(wcount - base == 5, "R8 post writes", 128'(wcount - base), 128'd5);
        step(20);
        chk(wcount - base == 5, "R8 none while halted", 128'(wcount - base), 128'd5);

        // disable clears
        cap_en = 1'b0;
        step(1);
        chk(cap_state === 2'd0, "R10 disabled state", {126'd0, cap_state}, 128'd0);
        chk(first_fill === 1'b1, "R9 rearm on disable", {127'd0, first_fill}, 128'd1);
        base = wcount;
        step(3);
        chk(wcount == base, "R10 no writes disabled", 128'(wcount - base), 128'd0);

        // 8-bit slices, decimate by 3, shift 16, region 2, mid-line trigger
        setup(3, 1, 3, 2, 2, 3);
        step(50);
        trig_in = 1'b1;
        step(1);
        trig_in = 1'b0;
        step(200);
        chk(cap_state === 2'd2, "R8 halted mode3", {126'd0, cap_state}, 128'd2);

        // 16-bit slices, shift 64, zero post count halts at once
        setup(2, 3, 0, 1, 1, 0);
        step(7);
        trig_in = 1'b1;
        step(1);
        trig_in = 1'b0;
        chk(cap_state === 2'd2, "R8 zero post count", {126'd0, cap_state}, 128'd2);
        base = wcount;
        step(20);
        chk(wcount == base, "R8 zero post no writes", 128'(wcount - base), 128'd0);

        // 32-bit slices, shift 32, rate 2, second trigger ignored
        setup(1, 2, 2, 0, 0, 4);
        step(5);
        trig_in = 1'b1;
        step(1);
        trig_in = 1'b0;
        saved_ptr = evt_addr;
        step(3);
        trig_in = 1'b1;
        step(1);
        trig_in = 1'b0;
        step(1);
        chk(evt_addr === saved_ptr, "R11 pointer kept", {110'd0, evt_addr}, {110'd0, saved_ptr});
        chk(cap_state === 2'd1, "R11 state kept", {126'd0, cap_state}, 128'd1);
        step(100);
        chk(cap_state === 2'd2, "R8 halted mode1", {126'd0, cap_state}, 128'd2);

        // rate 31, then a non-zero region wrap
        setup(0, 0, 31, 1, 1, 2);
        step(300);
        setup(0, 0, 1, 5, 5, 1);
        step(2100);
        chk(first_fill === 1'b0, "R4 R9 wrap at offset region", {127'd0, first_fill}, 128'd0);
        trig_in = 1'b1;
        step(1);
        trig_in = 1'b0;
        step(10);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule